// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers up to sixteen interrupt request lines into one pending register and drives a single level-sensitive interrupt line toward a processor. Devices set and clear pending bits through two bit-vector inputs. The host controls which lines may interrupt by writing a mask byte, and it retires a serviced request by writing that request's line number to an acknowledge port.

The mask is kept internally as an enable set, which is the bitwise inverse of the byte the host writes. Reading the mask port returns the byte as the host wrote it. The status output always shows the raw pending register, whether or not a line is masked. The interrupt output is recomputed on every event that can change either register. It is high exactly while some pending line is also enabled.

The controller does not resolve priority between lines, generate vectors or cascade to another controller. Every line is held as a sticky pending bit.

Top module: `masked_irq_ctrl`

## Requirements
- R1: After reset the status output reads 0x00, the mask read-back reads 0xFF (all lines masked) and `irq_o` is low.
- R2: A host write with `host_sel` = 2'b00 stores the inverse of `host_wdata` as the enable set, so a written 1 masks that line. From the next cycle on, `mask_rdata` returns the written byte.
- R3: `irq_o` is high exactly when the status and the inverse of `mask_rdata` share a set bit. It takes its new value in the cycle after the edge that changes either register.
- R4: A host write with `host_sel` = 2'b01 clears the pending bit whose index is `host_wdata[3:0]`. The upper data bits are ignored. An index at or above the line count clears nothing.
- R5: A one on `dev_raise` sets the matching pending bit at the next clock edge. That bit stays set until a clear or an acknowledge removes it.
- R6: A one on `dev_clear` clears the matching pending bit at the next clock edge.
- R7: When a line is raised in the same cycle that it is cleared or acknowledged, the raise wins and the bit ends up set.
- R8: `status_o` shows pending bits of masked lines as well as unmasked ones.
- R9: Unmasking a line that is already pending raises `irq_o`. Masking every pending line lowers it, and the pending bits are not changed.
- R10: Host writes with `host_sel` = 2'b10 or 2'b11 change neither register nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wen | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 2 | Write target: 00 mask, 01 acknowledge, 10/11 unused |
| host_wdata | input | DATA_W | Host write data |
| dev_raise | input | NUM_LINES | Per-line request set |
| dev_clear | input | NUM_LINES | Per-line request clear |
| mask_rdata | output | DATA_W | Mask read-back (inverse of the enables) |
| status_o | output | NUM_LINES | Raw pending register |
| irq_o | output | 1 | Level interrupt request |

## Verification
If the enable set is stored without the inversion, the fault shows on `mask_rdata` one cycle after the first mask write. The wrong enables then also reach `irq_o` as soon as any line is pending. A fault in the acknowledge index decode, or in the raise-over-clear ordering, leaves a wrong bit on `status_o` in the cycle after the write. A stale output flag appears as `irq_o` disagreeing with status and mask one cycle after the event that should have moved it. For these reasons the bench compares all three outputs after every stimulus cycle.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
   typedef enum logic [1:0] {
      SEL_MASK  = 2'b00,
      SEL_ACK   = 2'b01,
      SEL_RSVA  = 2'b10,
      SEL_RSVB  = 2'b11
   } host_sel_e;

   localparam int unsigned ACK_IDX_W = 4;
endpackage

// File: rtl/mirq_enable_reg.sv
module mirq_enable_reg #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_LINES-1:0] wr_mask,
   output logic [NUM_LINES-1:0] en_q,
   output logic [NUM_LINES-1:0] en_d,
   output logic [DATA_W-1:0]    mask_rdata
);
   localparam int unsigned PAD_W = (DATA_W > NUM_LINES) ? DATA_W - NUM_LINES : 1;

   always_comb en_d = wr_en ? ~wr_mask : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   generate
      if (DATA_W > NUM_LINES) begin : g_pad
         always_comb mask_rdata = {{PAD_W{1'b1}}, ~en_q};
      end else begin : g_exact
         always_comb mask_rdata = ~en_q;
      end
   endgenerate

   // R2: the read-back returns the byte the host wrote
   assert_mask_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_rdata[NUM_LINES-1:0] == $past(wr_mask)));
   // R10: with no mask write the enable set holds its value
   assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q));
endmodule

// File: rtl/mirq_pending_reg.sv
module mirq_pending_reg
   import mirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] raise,
   input  logic [NUM_LINES-1:0] clear,
   input  logic                 ack_en,
   input  logic [ACK_IDX_W-1:0] ack_idx,
   output logic [NUM_LINES-1:0] pend_q,
   output logic [NUM_LINES-1:0] pend_d
);
   logic [NUM_LINES-1:0] ack_hit;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         always_comb begin
            ack_hit[i] = ack_en && (ack_idx == ACK_IDX_W'(i));
            // a raise overrides a clear or acknowledge of the same line
            pend_d[i]  = raise[i] | (pend_q[i] & ~clear[i] & ~ack_hit[i]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R5 / R7: every raised line is pending one cycle later
   assert_raise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|raise) |=> ((pend_q & $past(raise)) == $past(raise)));
   // R6: a clear that is not overridden removes the bit
   assert_clear_removes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clear & ~raise)) |=> ((pend_q & $past(clear & ~raise)) == '0));
   // R4: an acknowledge clears at most one bit
   assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && raise == '0 && clear == '0) |=> ($countones($past(pend_q) & ~pend_q) <= 1));
endmodule

// File: rtl/mirq_out_track.sv
module mirq_out_track #(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pend_d,
   input  logic [NUM_LINES-1:0] en_d,
   output logic                 irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend_d & en_d);
   end
endmodule

// File: rtl/masked_irq_ctrl.sv
module masked_irq_ctrl
   import mirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wen,
   input  logic [1:0]           host_sel,
   input  logic [DATA_W-1:0]    host_wdata,
   input  logic [NUM_LINES-1:0] dev_raise,
   input  logic [NUM_LINES-1:0] dev_clear,
   output logic [DATA_W-1:0]    mask_rdata,
   output logic [NUM_LINES-1:0] status_o,
   output logic                 irq_o
);
   generate
      if (NUM_LINES < 1 || NUM_LINES > (1 << ACK_IDX_W)) begin : g_bad_lines
         $error("NUM_LINES must lie in 1..16");
      end
      if (DATA_W < NUM_LINES || DATA_W < ACK_IDX_W) begin : g_bad_width
         $error("DATA_W must cover NUM_LINES and the acknowledge index");
      end
   endgenerate

   host_sel_e            sel;
   logic                 mask_wr;
   logic                 ack_wr;
   logic [NUM_LINES-1:0] en_q, en_d, pend_q, pend_d;

   always_comb begin
      sel     = host_sel_e'(host_sel);
      mask_wr = host_wen && (sel == SEL_MASK);
      ack_wr  = host_wen && (sel == SEL_ACK);
   end

   mirq_enable_reg #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_enable (
      .clk(clk), .rst_n(rst_n), .wr_en(mask_wr),
      .wr_mask(host_wdata[NUM_LINES-1:0]),
      .en_q(en_q), .en_d(en_d), .mask_rdata(mask_rdata)
   );

   mirq_pending_reg #(.NUM_LINES(NUM_LINES)) u_pending (
      .clk(clk), .rst_n(rst_n), .raise(dev_raise), .clear(dev_clear),
      .ack_en(ack_wr), .ack_idx(host_wdata[ACK_IDX_W-1:0]),
      .pend_q(pend_q), .pend_d(pend_d)
   );

   mirq_out_track #(.NUM_LINES(NUM_LINES)) u_track (
      .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .en_d(en_d), .irq_q(irq_o)
   );

   always_comb status_o = pend_q;

   // R3: the output flag agrees with pending and mask at the ports
   assert_irq_consistent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(status_o & ~mask_rdata[NUM_LINES-1:0]));
   // R9: a mask write alone never changes the pending bits
   assert_mask_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && dev_raise == '0 && dev_clear == '0) |=> $stable(status_o));
endmodule

// File: tb/masked_irq_ctrl_tb.sv
module masked_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   typedef struct packed {
      logic       wen;
      logic [1:0] sel;
      logic [7:0] wdata;
      logic [7:0] raise;
      logic [7:0] clear;
      logic [7:0] e_pend;
      logic [7:0] e_mask;
      logic       e_irq;
      logic [7:0] req;
   } vec_t;

   localparam vec_t TBL [NV] = '{
      '{1'b1, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'd2},  // R2 enable all
      '{1'b0, 2'b00, 8'h00, 8'h05, 8'h00, 8'h05, 8'h00, 1'b1, 8'd5},  // R5 raise
      '{1'b1, 2'b00, 8'hFF, 8'h00, 8'h00, 8'h05, 8'hFF, 1'b0, 8'd9},  // R9 mask all, R8
      '{1'b1, 2'b00, 8'hFB, 8'h00, 8'h00, 8'h05, 8'hFB, 1'b1, 8'd9},  // R9 unmask line 2
      '{1'b1, 2'b01, 8'h02, 8'h00, 8'h00, 8'h01, 8'hFB, 1'b0, 8'd4},  // R4 ack line 2, R3
      '{1'b1, 2'b01, 8'h0A, 8'h00, 8'h00, 8'h01, 8'hFB, 1'b0, 8'd4},  // R4 index out of range
      '{1'b1, 2'b01, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hFB, 1'b0, 8'd4},  // R4 upper bits ignored
      '{1'b0, 2'b00, 8'h00, 8'h84, 8'h04, 8'h84, 8'hFB, 1'b1, 8'd7},  // R7 raise beats clear
      '{1'b0, 2'b00, 8'h00, 8'h00, 8'h04, 8'h80, 8'hFB, 1'b0, 8'd6},  // R6 clear
      '{1'b1, 2'b01, 8'h00, 8'h01, 8'h00, 8'h81, 8'hFB, 1'b0, 8'd7},  // R7 raise beats ack
      '{1'b1, 2'b10, 8'h00, 8'h00, 8'h00, 8'h81, 8'hFB, 1'b0, 8'd10}, // R10 sel 10
      '{1'b1, 2'b11, 8'h00, 8'h00, 8'h00, 8'h81, 8'hFB, 1'b0, 8'd10}, // R10 sel 11
      '{1'b1, 2'b00, 8'h7E, 8'h00, 8'h00, 8'h81, 8'h7E, 1'b1, 8'd3},  // R3 enable lines 0,7
      '{1'b0, 2'b00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h7E, 1'b0, 8'd6}   // R6 clear all
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wen = 1'b0;
   logic [1:0] host_sel = 2'b00;
   logic [7:0] host_wdata = '0;
   logic [7:0] dev_raise = '0;
   logic [7:0] dev_clear = '0;
   logic [7:0] mask_rdata;
   logic [7:0] status_o;
   logic       irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   masked_irq_ctrl #(.NUM_LINES(8), .DATA_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wen(host_wen), .host_sel(host_sel),
      .host_wdata(host_wdata), .dev_raise(dev_raise), .dev_clear(dev_clear),
      .mask_rdata(mask_rdata), .status_o(status_o), .irq_o(irq_o)
   );

   task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      host_wen = 1'b0; host_sel = 2'b00; host_wdata = '0;
      dev_raise = '0; dev_clear = '0;
   endtask

   task automatic reset_checks(input string tag);
      chk({tag, " status"}, 1, status_o, 8'h00);
      chk({tag, " mask"},   1, mask_rdata, 8'hFF);
      chk({tag, " irq"},    1, {7'd0, irq_o}, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      reset_checks("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      reset_checks("R1 after reset");

      for (int i = 0; i < NV; i++) begin
         host_wen   = TBL[i].wen;
         host_sel   = TBL[i].sel;
         host_wdata = TBL[i].wdata;
         dev_raise  = TBL[i].raise;
         dev_clear  = TBL[i].clear;
         @(negedge clk);
         chk($sformatf("vec %0d status", i), int'(TBL[i].req), status_o, TBL[i].e_pend);
         chk($sformatf("vec %0d mask", i),   int'(TBL[i].req), mask_rdata, TBL[i].e_mask);
         chk($sformatf("vec %0d irq", i),    int'(TBL[i].req), {7'd0, irq_o}, {7'd0, TBL[i].e_irq});
      end
      idle_inputs();

      // R8: masked pending line still visible, output stays low
      host_wen = 1'b1; host_sel = 2'b00; host_wdata = 8'hFF;
      @(negedge clk);
      idle_inputs(); dev_raise = 8'h40;
      @(negedge clk);
      idle_inputs();
      chk("R8 masked line visible", 8, status_o, 8'h40);
      chk("R8 masked line no irq", 8, {7'd0, irq_o}, 8'h00);
      // R3: output holds high while idle after unmasking
      host_wen = 1'b1; host_sel = 2'b00; host_wdata = 8'hBF;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      chk("R3 irq held", 3, {7'd0, irq_o}, 8'h01);

      // R1: reset in mid-run restores reset state
      rst_n = 1'b0;
      @(negedge clk);
      reset_checks("R1 mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule